// File: doc/BRIEF.md
# 8b10b Comma Word Aligner

This block sits behind a serial-to-parallel front end that delivers 40 raw line bits per clock with no fixed relation to symbol boundaries. The bits carry four 10-bit 8b10b symbols. The aligner looks for the K28.5 control character, which is the byte 0xBC sent as a control code. It recognises either of the two running-disparity encodings of that character. When it finds one, it picks the bit offset that puts the comma in the lowest symbol slot. Every word it outputs then starts on a four-symbol boundary, which corresponds to a 32-bit boundary after decoding.

The search runs over an 80-bit window. The window is the current input word placed above the previous one, and all 40 start offsets are compared against both comma codes at the same time. The output word is the 40 window bits that begin at the selected offset, registered once. The control logic is a three-state machine.

- `ST_HUNT`: after reset, no offset is trusted.
- `ST_LOCKED`: an offset is in force.
- `ST_SUSPECT`: locked, and a comma has been seen at some other offset.

The transitions are as follows.

- HUNT→LOCKED on the first detection. The lowest matching offset is taken.
- LOCKED→SUSPECT on a comma at a different offset, with the candidate count set to one.
- SUSPECT→SUSPECT in two cases. A comma at the same candidate offset advances the count. A comma at yet another offset restarts the count at one for that offset.
- SUSPECT→LOCKED when a comma reappears at the locked offset. The count is dropped.
- SUSPECT→LOCKED, realigning, on the third detection at the candidate offset. The candidate becomes the new locked offset.

Cycles without any comma leave the state and count unchanged. Reset returns the machine to HUNT.

Top module: `comma_word_aligner`

## Requirements
- R1: With `rst` high at a clock edge, the next outputs are `aligned`=0, `comma_det`=0 and `dout`=0, and the machine returns to hunting. This holds even when a lock was held before.
- R2: The comma codes are defined in first-received order, bit a first: the negative-disparity form is 0011111010 and the positive form is 1100000101. `din[0]` is the earliest bit of a word, and the whole previous word precedes the current one. While hunting, a comma found at any of the 40 offsets locks that offset. In the same edge, `aligned` rises and the output word holds the comma in `dout[9:0]`.
- R3: `dout` after edge t is the 40 stream bits that start k bits into the word applied at edge t-1, where k is the offset in force. This gives one cycle of latency. While hunting, k is 0, so `dout` equals the previous input word.
- R4: `comma_det` is high after an edge exactly when that edge's output word holds an enabled comma in `dout[9:0]` at the offset in force.
- R5: `pos_en` gates the positive form and `neg_en` gates the negative form. `det_en` gates both. A comma whose form is disabled neither locks the block nor pulses `comma_det`.
- R6: While locked, holding `det_en` low keeps `aligned` high and the offset unchanged, and holds `comma_det` low.
- R7: While locked, a comma at the locked offset leaves the offset unchanged and clears any pending count of commas seen at another offset.
- R8: A third detection at the same different offset realigns the block. In that edge `dout` switches to the new offset, `comma_det` is high and `aligned` is low for that one cycle only. Cycles without a comma do not break the run of three.
- R9: A comma at an offset that is neither the locked one nor the current candidate becomes the new candidate, and its count restarts at one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| det_en | input | 1 | Master enable for comma detection |
| pos_en | input | 1 | Enable for the positive-disparity comma |
| neg_en | input | 1 | Enable for the negative-disparity comma |
| din | input | 40 | Unaligned raw line word, bit 0 received first |
| dout | output | 40 | Aligned word, comma slot in bits 9:0 |
| aligned | output | 1 | Offset in force and trusted |
| comma_det | output | 1 | Output word carries a comma in its lowest slot |

## Verification
The realign decision and the comma pulse land in the same edge. In that cycle `aligned` must drop while `comma_det` is high and `dout` already shows the new offset. Likewise, the first lock raises `aligned` and `comma_det` together on a word that is already shifted. These cases are provoked by streams that move the comma position mid-run. Some of those streams move it steadily, some with idle gaps, some with a stray third offset, and one with a return to the old position. In each cycle, all three outputs are compared against the stream bits that the bench computes at the expected offset.

// File: rtl/aligner_pkg.sv
package aligner_pkg;
    // K28.5 codes, bit 0 = first bit on the line
    parameter logic [9:0] KCHAR_NEG = 10'h17C;
    parameter logic [9:0] KCHAR_POS = 10'h283;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_LOCKED  = 2'd1,
        ST_SUSPECT = 2'd2
    } align_state_t;
endpackage

// File: rtl/comma_match_array.sv
module comma_match_array #(
    parameter int WORD_W = 40,
    parameter int SYM_W  = 10
) (
    input  logic [2*WORD_W-1:0] win,
    input  logic                en_pos,
    input  logic                en_neg,
    output logic [WORD_W-1:0]   hits
);
    import aligner_pkg::*;

    for (genvar k = 0; k < WORD_W; k++) begin : g_off
        logic [SYM_W-1:0] slice;
        assign slice   = win[k +: SYM_W];
        assign hits[k] = (en_pos && slice == KCHAR_POS) ||
                         (en_neg && slice == KCHAR_NEG);
    end
endmodule

// File: rtl/lowest_hit_enc.sv
module lowest_hit_enc #(
    parameter int N = 40,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/window_shifter.sv
module window_shifter #(
    parameter int WORD_W = 40,
    localparam int OFF_W = $clog2(WORD_W)
) (
    input  logic [2*WORD_W-1:0] win,
    input  logic [OFF_W-1:0]    off,
    output logic [WORD_W-1:0]   word
);
    logic [2*WORD_W-1:0] sh;

    always_comb begin
        sh   = win >> off;
        word = sh[WORD_W-1:0];
    end
endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner #(
    parameter int WORD_W  = 40,
    parameter int SYM_W   = 10,
    parameter int CONFIRM = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              det_en,
    input  logic              pos_en,
    input  logic              neg_en,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout,
    output logic              aligned,
    output logic              comma_det
);
    import aligner_pkg::*;

    localparam int OFF_W = $clog2(WORD_W);
    localparam int CNT_W = $clog2(CONFIRM + 1);

    logic [WORD_W-1:0]   prev_q;
    logic [2*WORD_W-1:0] win;
    logic [WORD_W-1:0]   hits;
    logic                any_hit;
    logic [OFF_W-1:0]    hit_idx;
    logic [WORD_W-1:0]   shifted;

    align_state_t     state_q, state_d;
    logic [OFF_W-1:0] off_q, off_d;
    logic [OFF_W-1:0] cand_q, cand_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             realign;

    assign win = {din, prev_q};

    comma_match_array #(.WORD_W(WORD_W), .SYM_W(SYM_W)) match_i (
        .win    (win),
        .en_pos (det_en && pos_en),
        .en_neg (det_en && neg_en),
        .hits   (hits)
    );

    lowest_hit_enc #(.N(WORD_W)) enc_i (
        .req (hits),
        .any (any_hit),
        .idx (hit_idx)
    );

    window_shifter #(.WORD_W(WORD_W)) shift_i (
        .win  (win),
        .off  (off_d),
        .word (shifted)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        off_d   = off_q;
        cand_d  = cand_q;
        cnt_d   = cnt_q;
        realign = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                if (any_hit) begin
                    off_d   = hit_idx;
                    cnt_d   = '0;
                    state_d = ST_LOCKED;
                end
            end
            ST_LOCKED, ST_SUSPECT: begin
                if (hits[off_q]) begin
                    state_d = ST_LOCKED;
                    cnt_d   = '0;
                end else if (any_hit) begin
                    if (state_q == ST_SUSPECT && hit_idx == cand_q) begin
                        if (cnt_q == CNT_W'(CONFIRM - 1)) begin
                            realign = 1'b1;
                            off_d   = hit_idx;
                            cnt_d   = '0;
                            state_d = ST_LOCKED;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end else begin
                        cand_d  = hit_idx;
                        cnt_d   = CNT_W'(1);
                        state_d = ST_SUSPECT;
                    end
                end
            end
            default: state_d = ST_HUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HUNT;
            off_q   <= '0;
            cand_q  <= '0;
            cnt_q   <= '0;
            prev_q  <= '0;
        end else begin
            state_q <= state_d;
            off_q   <= off_d;
            cand_q  <= cand_d;
            cnt_q   <= cnt_d;
            prev_q  <= din;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            dout      <= '0;
            aligned   <= 1'b0;
            comma_det <= 1'b0;
        end else begin
            dout      <= shifted;
            aligned   <= (state_d != ST_HUNT) && !realign;
            comma_det <= (state_d != ST_HUNT) && hits[off_d];
        end
    end

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!aligned && !comma_det && state_q == ST_HUNT));

    // R2
    a_r2_hunt_unaligned: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HUNT) |-> !aligned);

    // R2
    a_r2_pick_is_hit: assert property (@(posedge clk) disable iff (rst)
        any_hit |-> hits[hit_idx]);

    // R4
    a_r4_det_shows_comma: assert property (@(posedge clk) disable iff (rst)
        comma_det |-> (dout[SYM_W-1:0] == KCHAR_NEG || dout[SYM_W-1:0] == KCHAR_POS));

    // R6, R7
    a_r7_offset_hold: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_HUNT && !realign) |=> (off_q == $past(off_q)));

    // R7
    a_r7_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_HUNT) |=> (state_q != ST_HUNT));

    // R8
    a_r8_single_gap: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOCKED && !aligned) |=> aligned);

    // R9
    a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CNT_W'(CONFIRM));
endmodule

// File: tb/comma_word_aligner_tb.sv
`timescale 1ns/1ps
module comma_word_aligner_tb_top;
    localparam int W  = 40;
    localparam int NW = 24;
    localparam logic [9:0] P_NEG = 10'b0101111100; // 0011111010 reversed
    localparam logic [9:0] P_POS = 10'b1010000011; // 1100000101 reversed

    logic         clk = 1'b0;
    logic         rst;
    logic         det_en, pos_en, neg_en;
    logic [W-1:0] din;
    logic [W-1:0] dout;
    logic         aligned, comma_det;

    always #10 clk = ~clk;

    comma_word_aligner dut_i (
        .clk(clk), .rst(rst), .det_en(det_en), .pos_en(pos_en), .neg_en(neg_en),
        .din(din), .dout(dout), .aligned(aligned), .comma_det(comma_det)
    );

    int ph [NW];
    bit pl [NW];
    bit de [NW];
    bit e_al [NW];
    bit e_det [NW];
    int e_off [NW];
    int nchk = 0;
    int nbad = 0;
    int cyc  = 0;

    function automatic logic [9:0] pat(bit pos);
        return pos ? P_POS : P_NEG;
    endfunction

    function automatic logic sbit(int n);
        logic [9:0] p;
        int w, b;
        if (n < 0) return 1'b0;
        w = n / 40;
        b = n % 40;
        if (w < NW && ph[w] >= 0 && b >= ph[w] && b - ph[w] < 10) begin
            p = pat(pl[w]);
            return p[b - ph[w]];
        end
        if (w >= 1 && w - 1 < NW && ph[w-1] > 30 && b + 40 - ph[w-1] < 10) begin
            p = pat(pl[w-1]);
            return p[b + 40 - ph[w-1]];
        end
        return (n % 2) == 1;
    endfunction

    function automatic logic [W-1:0] word_at(int base);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = sbit(base + i);
        return r;
    endfunction

    task automatic chk(string tag, string what, logic [W-1:0] got, logic [W-1:0] exp);
        nchk++;
        if (got !== exp) begin
            nbad++;
            $display("FAIL %s %s at %0t: got %h expected %h", tag, what, $time, got, exp);
        end
    endtask

    task automatic clear_plan();
        for (int w = 0; w < NW; w++) begin
            ph[w] = -1; pl[w] = 0; de[w] = 1;
            e_al[w] = 0; e_det[w] = 0; e_off[w] = 0;
        end
    endtask

    task automatic set_ph(int a, int b, int p, bit pos);
        for (int w = a; w <= b; w++) begin ph[w] = p; pl[w] = pos; end
    endtask

    task automatic expect_rng(int a, int b, bit al, bit dt, int off);
        for (int t = a; t <= b; t++) begin e_al[t] = al; e_det[t] = dt; e_off[t] = off; end
    endtask

    task automatic run(int n, string tag_al, string tag_det, bit pe, bit ne);
        rst = 1'b1; din = '0; det_en = 1'b1; pos_en = pe; neg_en = ne;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R1", "aligned", W'(aligned), W'(1'b0));
        chk("R1", "comma_det", W'(comma_det), W'(1'b0));
        chk("R1", "dout", dout, '0);
        rst = 1'b0;
        for (int t = 0; t < n; t++) begin
            det_en = de[t];
            din    = word_at(40 * t);
            @(posedge clk); @(negedge clk);
            chk(tag_al, "aligned", W'(aligned), W'(e_al[t]));
            chk(tag_det, "comma_det", W'(comma_det), W'(e_det[t]));
            chk("R3", "dout", dout, word_at(40 * (t - 1) + e_off[t]));
        end
    endtask

    initial begin
        // R2 R3 R4 R5: every offset, both codes, four enable mixes
        for (int pol = 0; pol < 2; pol++) begin
            for (int p = 0; p < 40; p++) begin
                for (int c = 0; c < 4; c++) begin
                    bit dall, pe, ne, lk;
                    dall = (c != 3); pe = (c != 2); ne = (c != 1);
                    clear_plan();
                    set_ph(2, 7, p, bit'(pol));
                    for (int w = 0; w < NW; w++) de[w] = dall;
                    lk = dall && (pol == 1 ? pe : ne);
                    if (lk) expect_rng(3, 7, 1, 1, p);
                    if (c == 0) run(8, "R2", "R4", pe, ne);
                    else        run(8, "R5", "R5", pe, ne);
                end
            end
        end

        // R8: steady move to a new offset and code
        clear_plan();
        set_ph(2, 9, 5, 0); set_ph(10, 19, 23, 1);
        expect_rng(3, 10, 1, 1, 5); expect_rng(11, 12, 1, 0, 5);
        expect_rng(13, 13, 0, 1, 23); expect_rng(14, 20, 1, 1, 23);
        run(21, "R8", "R8", 1, 1);

        // R7: return to the locked offset clears the pending count
        clear_plan();
        set_ph(2, 5, 5, 0); set_ph(6, 7, 17, 0); set_ph(8, 8, 5, 0);
        set_ph(9, 10, 17, 0); set_ph(11, 15, 5, 0);
        expect_rng(3, 6, 1, 1, 5); expect_rng(7, 8, 1, 0, 5);
        expect_rng(9, 9, 1, 1, 5); expect_rng(10, 11, 1, 0, 5);
        expect_rng(12, 16, 1, 1, 5);
        run(17, "R7", "R7", 1, 1);

        // R8: idle words between the three sightings
        clear_plan();
        set_ph(2, 5, 5, 0); set_ph(6, 6, 17, 0); set_ph(8, 8, 17, 0);
        set_ph(10, 13, 17, 0);
        expect_rng(3, 6, 1, 1, 5); expect_rng(7, 10, 1, 0, 5);
        expect_rng(11, 11, 0, 1, 17); expect_rng(12, 14, 1, 1, 17);
        run(15, "R8", "R8", 1, 1);

        // R9: stray third offset restarts the candidate count
        clear_plan();
        set_ph(2, 5, 5, 0); set_ph(6, 6, 17, 0); set_ph(7, 7, 23, 0);
        set_ph(8, 13, 17, 0);
        expect_rng(3, 6, 1, 1, 5); expect_rng(7, 10, 1, 0, 5);
        expect_rng(11, 11, 0, 1, 17); expect_rng(12, 14, 1, 1, 17);
        run(15, "R9", "R9", 1, 1);

        // R6: master enable dropped while locked
        clear_plan();
        set_ph(2, 11, 12, 1);
        for (int w = 6; w < NW; w++) de[w] = 0;
        expect_rng(3, 5, 1, 1, 12); expect_rng(6, 12, 1, 0, 12);
        run(13, "R6", "R6", 1, 1);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nchk++; nbad++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
            $finish;
        end
    end
endmodule